// File: doc/BRIEF.md
# Debug-to-APB Memory Access Port

This block turns word accesses on a small 32-bit debug register interface into transfers on an APB master port. The debug side sees a control/status word and a transfer address. It also sees a main data register, four banked data windows and two read-only constants: a base address and an identification word. Reading or writing the main data register or a banked window runs one APB transfer and returns its result. Accesses to every other register complete at once, without touching the bus.

The main data register uses the transfer address. When the increment field is set to "on", that address advances by one word after each successful transfer. The four banked windows reach the four words of the 16-byte aligned region that holds the transfer address, and they never move it. An APB error response comes back to the debug side as an error flag, and the address is then left where it was. A software-access-enable output comes from the control word. It is low during reset and goes high one clock after reset is released.

The sequencing is a four-state machine: IDLE, SETUP, ACCESS and RESP. IDLE→SETUP fires when a data access is requested. SETUP→ACCESS is unconditional. ACCESS→RESP fires when pready is high. ACCESS→ACCESS holds while pready is low. RESP→IDLE is unconditional. The debug requester holds `dbg_req` and its fields until `dbg_ready` is high at a clock edge.

Top module: `dbg_apb_port`

## Requirements
- R1: The control word is at offset 0x00. It reads as {sw_en[31], zeros[30:12], mode[11:8], busy[7], dev_en[6], inc[5:4], 0[3], 3'b010[2:0]}. The mode and inc fields are writable, and both reset to zero. Bit 7 is high exactly while an APB transfer occupies the bus. A read of an unmapped offset (for example 0x08) returns zero.
- R2: `sw_access_en` is 0 while reset is asserted and in the first cycle after release. It is 1 from the first clock edge after release onward. After that it follows writes to control bit 31.
- R3: The transfer address is at offset 0x04. Writes store bits [31:2] only, and bits [1:0] always read as zero.
- R4: An access to the main data register at 0x0C drives paddr = {TAR[31:2], 2'b00}.
- R5: An access to a banked window at 0x10/0x14/0x18/0x1C drives paddr = {TAR[31:4], dbg_addr[3:2], 2'b00}.
- R6: After a successful main-data transfer with inc = 2'b01, TAR increases by 4. With inc = 2'b00, 2'b10 or 2'b11, TAR does not change.
- R7: A transfer that ends with pslverr sets `dbg_err` in its response cycle and leaves TAR unchanged.
- R8: Each APB transfer has exactly one setup cycle (psel=1, penable=0), then an access phase (psel=1, penable=1) held until pready. paddr stays stable throughout.
- R9: A register access is ready in the cycle it is requested. A data access is ready three cycles after the request plus one cycle per APB wait state, and `dbg_ready` is low while the bus is occupied. A read returns the prdata of its transfer, and a write's data appears on pwdata.
- R10: The base register at 0xF8 returns the BASE_ADDR parameter. The identification register at 0xFC returns {REVISION[31:28], CONT_CODE[27:24], MFR_CODE[23:17], MEM_AP[16], 8'h00, IDENT[7:0]}.
- R11: Banked window accesses never change TAR, whatever the inc field holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dbg_req | input | 1 | Debug access request, held until ready |
| dbg_write | input | 1 | 1 = write, 0 = read |
| dbg_addr | input | 8 | Debug register byte offset |
| dbg_wdata | input | 32 | Debug write data |
| dbg_rdata | output | 32 | Debug read data, valid with dbg_ready |
| dbg_ready | output | 1 | Access completes at this clock edge |
| dbg_err | output | 1 | APB error response for the completing access |
| dev_en | input | 1 | Device-enable status, shown in the control word |
| sw_access_en | output | 1 | Software access enable |
| paddr | output | 32 | APB address |
| psel | output | 1 | APB select |
| penable | output | 1 | APB enable |
| pwrite | output | 1 | APB direction |
| pwdata | output | 32 | APB write data |
| prdata | input | 32 | APB read data |
| pready | input | 1 | APB ready |
| pslverr | input | 1 | APB error response |

## Verification
The assertions check the bus protocol on every cycle: the setup-to-access step, access-phase stability, aligned addresses, no debug ready while the bus is occupied, and the busy bit tracking psel. They also check the address-update rules at each transfer completion: no change on error or banked access, and a step of 4 when increment is on. Only the bench scenarios can show the actual address values, the returned data, the response latency for each wait-state count, the reset-release behaviour of the enable output, and the constant and control-word read values.

// File: rtl/dbg_apb_pkg.sv
package dbg_apb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETUP,
        ST_ACCESS,
        ST_RESP
    } xfer_state_t;

    localparam logic [7:0] OFS_CSW  = 8'h00;
    localparam logic [7:0] OFS_TAR  = 8'h04;
    localparam logic [7:0] OFS_DRW  = 8'h0C;
    localparam logic [7:0] OFS_BASE = 8'hF8;
    localparam logic [7:0] OFS_IDR  = 8'hFC;
    localparam logic [3:0] BANK_ROW = 4'h1;

    localparam logic [1:0] INC_ON    = 2'b01;
    localparam logic [2:0] SIZE_WORD = 3'b010;
endpackage

// File: rtl/apb_xfer_fsm.sv
module apb_xfer_fsm
    import dbg_apb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    input  logic pready,
    output logic psel,
    output logic penable,
    output logic launch,
    output logic finish,
    output logic respond
);
    xfer_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (go) state_d = ST_SETUP;
            ST_SETUP:  state_d = ST_ACCESS;
            ST_ACCESS: if (pready) state_d = ST_RESP;
            ST_RESP:   state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        psel    = 1'b0;
        penable = 1'b0;
        launch  = 1'b0;
        finish  = 1'b0;
        respond = 1'b0;
        unique case (state_q)
            ST_IDLE:   launch = go;
            ST_SETUP:  psel = 1'b1;
            ST_ACCESS: begin
                psel    = 1'b1;
                penable = 1'b1;
                finish  = pready;
            end
            ST_RESP:   respond = 1'b1;
        endcase
    end
endmodule

// File: rtl/dbg_apb_regs.sv
module dbg_apb_regs
    import dbg_apb_pkg::*;
#(
    parameter int          AW        = 32,
    parameter int          DW        = 32,
    parameter int          OAW       = 8,
    parameter logic [31:0] BASE_ADDR = 32'hC000_0003,
    parameter logic [3:0]  REVISION  = 4'h1,
    parameter logic [3:0]  CONT_CODE = 4'h2,
    parameter logic [6:0]  MFR_CODE  = 7'h15,
    parameter logic        MEM_AP    = 1'b1,
    parameter logic [7:0]  IDENT     = 8'h07
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           reg_wr,
    input  logic [OAW-1:0] reg_addr,
    input  logic [DW-1:0]  wdata,
    input  logic           launch,
    input  logic           launch_bank,
    input  logic           launch_write,
    input  logic           finish,
    input  logic [DW-1:0]  prdata,
    input  logic           pslverr,
    input  logic           busy,
    input  logic           dev_en,
    output logic [DW-1:0]  rd_word,
    output logic [DW-1:0]  csw_word,
    output logic [DW-1:0]  data_q,
    output logic           err_q,
    output logic [AW-1:0]  tar_q,
    output logic           bank_q,
    output logic [AW-1:0]  paddr_q,
    output logic           pwrite_q,
    output logic [DW-1:0]  pwdata_q,
    output logic           sw_en_q
);
    localparam int TW = AW - 2;

    logic [TW-1:0] tar_hi;
    logic [3:0]    mode_q;
    logic [1:0]    inc_q;
    logic          out_seen_q;

    assign tar_q    = {tar_hi, 2'b00};
    assign csw_word = {sw_en_q, 19'd0, mode_q, busy, dev_en, inc_q, 1'b0, SIZE_WORD};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_seen_q <= 1'b0;
            sw_en_q    <= 1'b0;
            mode_q     <= '0;
            inc_q      <= '0;
        end else begin
            out_seen_q <= 1'b1;
            if (reg_wr && reg_addr == OFS_CSW) begin
                sw_en_q <= wdata[31];
                mode_q  <= wdata[11:8];
                inc_q   <= wdata[5:4];
            end else if (!out_seen_q) begin
                sw_en_q <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tar_hi <= '0;
        end else if (reg_wr && reg_addr == OFS_TAR) begin
            tar_hi <= wdata[AW-1:2];
        end else if (finish && !bank_q && !pslverr && inc_q == INC_ON) begin
            tar_hi <= tar_hi + TW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            paddr_q  <= '0;
            pwrite_q <= 1'b0;
            pwdata_q <= '0;
            bank_q   <= 1'b0;
            data_q   <= '0;
            err_q    <= 1'b0;
        end else if (launch) begin
            paddr_q  <= launch_bank ? {tar_hi[TW-1:2], reg_addr[3:2], 2'b00} : {tar_hi, 2'b00};
            pwrite_q <= launch_write;
            pwdata_q <= wdata;
            bank_q   <= launch_bank;
            if (launch_write) data_q <= wdata;
        end else if (finish) begin
            err_q <= pslverr;
            if (!pwrite_q) data_q <= prdata;
        end
    end

    always_comb begin
        case (reg_addr)
            OFS_CSW:  rd_word = csw_word;
            OFS_TAR:  rd_word = tar_q;
            OFS_BASE: rd_word = BASE_ADDR;
            OFS_IDR:  rd_word = {REVISION, CONT_CODE, MFR_CODE, MEM_AP, 8'h00, IDENT};
            default:  rd_word = '0;
        endcase
    end
endmodule

// File: rtl/dbg_apb_port.sv
module dbg_apb_port
    import dbg_apb_pkg::*;
#(
    parameter int          AW        = 32,
    parameter int          DW        = 32,
    parameter int          OAW       = 8,
    parameter logic [31:0] BASE_ADDR = 32'hC000_0003,
    parameter logic [3:0]  REVISION  = 4'h1,
    parameter logic [3:0]  CONT_CODE = 4'h2,
    parameter logic [6:0]  MFR_CODE  = 7'h15,
    parameter logic        MEM_AP    = 1'b1,
    parameter logic [7:0]  IDENT     = 8'h07
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           dbg_req,
    input  logic           dbg_write,
    input  logic [OAW-1:0] dbg_addr,
    input  logic [DW-1:0]  dbg_wdata,
    output logic [DW-1:0]  dbg_rdata,
    output logic           dbg_ready,
    output logic           dbg_err,
    input  logic           dev_en,
    output logic           sw_access_en,
    output logic [AW-1:0]  paddr,
    output logic           psel,
    output logic           penable,
    output logic           pwrite,
    output logic [DW-1:0]  pwdata,
    input  logic [DW-1:0]  prdata,
    input  logic           pready,
    input  logic           pslverr
);
    logic          is_bank, is_data, idle;
    logic          go, launch, xfer_done, respond, reg_wr;
    logic [DW-1:0] rd_word, csw_word, data_q;
    logic [AW-1:0] tar_q;
    logic          err_q, bank_q;

    assign is_bank = dbg_addr[7:4] == BANK_ROW;
    assign is_data = is_bank || dbg_addr == OFS_DRW;
    assign idle    = !psel && !respond;
    assign go      = idle && dbg_req && is_data;
    assign reg_wr  = idle && dbg_req && dbg_write && !is_data;

    apb_xfer_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (go),
        .pready  (pready),
        .psel    (psel),
        .penable (penable),
        .launch  (launch),
        .finish  (xfer_done),
        .respond (respond)
    );

    dbg_apb_regs #(
        .AW(AW), .DW(DW), .OAW(OAW), .BASE_ADDR(BASE_ADDR), .REVISION(REVISION),
        .CONT_CODE(CONT_CODE), .MFR_CODE(MFR_CODE), .MEM_AP(MEM_AP), .IDENT(IDENT)
    ) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .reg_wr       (reg_wr),
        .reg_addr     (dbg_addr),
        .wdata        (dbg_wdata),
        .launch       (launch),
        .launch_bank  (is_bank),
        .launch_write (dbg_write),
        .finish       (xfer_done),
        .prdata       (prdata),
        .pslverr      (pslverr),
        .busy         (psel),
        .dev_en       (dev_en),
        .rd_word      (rd_word),
        .csw_word     (csw_word),
        .data_q       (data_q),
        .err_q        (err_q),
        .tar_q        (tar_q),
        .bank_q       (bank_q),
        .paddr_q      (paddr),
        .pwrite_q     (pwrite),
        .pwdata_q     (pwdata),
        .sw_en_q      (sw_access_en)
    );

    assign dbg_ready = respond || (idle && dbg_req && !is_data);
    assign dbg_rdata = respond ? data_q : rd_word;
    assign dbg_err   = respond && err_q;
endmodule

// File: rtl/dbg_apb_chk.sv
module dbg_apb_chk #(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          psel,
    input logic          penable,
    input logic          pready,
    input logic          pslverr,
    input logic [AW-1:0] paddr,
    input logic          dbg_ready,
    input logic [AW-1:0] tar,
    input logic          xfer_done,
    input logic          bank_q,
    input logic [DW-1:0] csw_word
);
    AST_SETUP_TO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        psel && !penable |=> psel && penable); // R8
    AST_ACCESS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        psel && penable && !pready |=> psel && penable && $stable(paddr)); // R8
    AST_ENABLE_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        penable |-> psel); // R8
    AST_TAR_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        tar[1:0] == 2'b00); // R3
    AST_PADDR_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        psel |-> paddr[1:0] == 2'b00); // R4
    AST_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        psel |-> !dbg_ready); // R9
    AST_BUSY_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        csw_word[7] == psel); // R1
    AST_NO_INC_ON_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done && pslverr |=> $stable(tar)); // R7
    AST_BANK_NO_INC: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done && bank_q |=> $stable(tar)); // R11
    AST_INC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done && !bank_q && !pslverr && csw_word[5:4] == 2'b01
        |=> tar == $past(tar) + AW'(4)); // R6
endmodule

bind dbg_apb_port dbg_apb_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .psel      (psel),
    .penable   (penable),
    .pready    (pready),
    .pslverr   (pslverr),
    .paddr     (paddr),
    .dbg_ready (dbg_ready),
    .tar       (tar_q),
    .xfer_done (xfer_done),
    .bank_q    (bank_q),
    .csw_word  (csw_word)
);

// File: tb/dbg_apb_port_tb_top.sv
module dbg_apb_port_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dbg_req = 1'b0, dbg_write = 1'b0;
    logic [7:0]  dbg_addr = '0;
    logic [31:0] dbg_wdata = '0, dbg_rdata;
    logic        dbg_ready, dbg_err, dev_en = 1'b1, sw_access_en;
    logic [31:0] paddr, pwdata, prdata;
    logic        psel, penable, pwrite, pready, pslverr;

    int checks = 0, errors = 0;
    int wait_cfg = 0, wcnt = 0;
    logic [31:0] err_addr = 32'hFFFF_FFF0;
    logic [31:0] last_addr = '0;
    logic [31:0] mem [16];
    logic [31:0] exp_mem [16];

    always #10 clk = ~clk;

    dbg_apb_port dut_i (
        .clk(clk), .rst_n(rst_n), .dbg_req(dbg_req), .dbg_write(dbg_write),
        .dbg_addr(dbg_addr), .dbg_wdata(dbg_wdata), .dbg_rdata(dbg_rdata),
        .dbg_ready(dbg_ready), .dbg_err(dbg_err), .dev_en(dev_en),
        .sw_access_en(sw_access_en), .paddr(paddr), .psel(psel), .penable(penable),
        .pwrite(pwrite), .pwdata(pwdata), .prdata(prdata), .pready(pready),
        .pslverr(pslverr)
    );

    assign pready  = psel && penable && (wcnt == wait_cfg);
    assign pslverr = pready && (paddr == err_addr);
    assign prdata  = mem[paddr[5:2]];

    always_ff @(posedge clk) begin
        if (psel && penable) begin
            if (pready) begin
                wcnt      <= 0;
                last_addr <= paddr;
                if (pwrite && !pslverr) mem[paddr[5:2]] <= pwdata;
            end else begin
                wcnt <= wcnt + 1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Called just after a rising edge; returns after the completing edge.
    task automatic acc(input bit wr, input logic [7:0] a, input logic [31:0] wd,
                       output logic [31:0] rd, output logic er, output int cyc);
        bit got = 0;
        dbg_req = 1'b1; dbg_write = wr; dbg_addr = a; dbg_wdata = wd;
        cyc = 0; rd = '0; er = 1'b0;
        while (!got) begin
            #2;
            if (dbg_ready) begin
                rd = dbg_rdata; er = dbg_err; got = 1;
            end
            @(posedge clk); #1;
            if (!got) cyc++;
        end
        dbg_req = 1'b0; dbg_write = 1'b0;
    endtask

    logic [31:0] rd, exp_a, d;
    logic        er;
    int          cyc;

    initial begin
        for (int i = 0; i < 16; i++) begin
            mem[i] = 32'hA500_0000 | (i * 32'h111);
            exp_mem[i] = mem[i];
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(sw_access_en == 1'b0, "R2 reset", {31'd0, sw_access_en}, 32'd0);
        chk(psel == 1'b0 && dbg_ready == 1'b0, "R8 reset idle", {30'd0, psel, dbg_ready}, 32'd0);
        rst_n = 1'b1;
        #2;
        chk(sw_access_en == 1'b0, "R2 before first edge", {31'd0, sw_access_en}, 32'd0);
        @(posedge clk); #1;
        chk(sw_access_en == 1'b1, "R2 after first edge", {31'd0, sw_access_en}, 32'd1);

        acc(0, 8'h00, 0, rd, er, cyc);
        chk(rd == 32'h8000_0042, "R1 csw reset value", rd, 32'h8000_0042);
        chk(cyc == 0, "R9 register latency", cyc, 0);
        dev_en = 1'b0;
        acc(0, 8'h00, 0, rd, er, cyc);
        chk(rd == 32'h8000_0002, "R1 dev_en low", rd, 32'h8000_0002);
        acc(1, 8'h00, 32'h0000_0F30, rd, er, cyc);
        acc(0, 8'h00, 0, rd, er, cyc);
        chk(rd == 32'h0000_0F32, "R1 csw write", rd, 32'h0000_0F32);
        chk(sw_access_en == 1'b0, "R2 cleared by write", {31'd0, sw_access_en}, 32'd0);
        acc(1, 8'h00, 32'hFFFF_FFFF, rd, er, cyc);
        acc(0, 8'h00, 0, rd, er, cyc);
        chk(rd == 32'h8000_0F32, "R1 reserved bits zero", rd, 32'h8000_0F32);
        chk(sw_access_en == 1'b1, "R2 set by write", {31'd0, sw_access_en}, 32'd1);
        dev_en = 1'b1;

        acc(1, 8'h04, 32'h0000_1237, rd, er, cyc);
        acc(0, 8'h04, 0, rd, er, cyc);
        chk(rd == 32'h0000_1234, "R3 tar low bits", rd, 32'h0000_1234);
        acc(0, 8'hF8, 0, rd, er, cyc);
        chk(rd == 32'hC000_0003, "R10 base", rd, 32'hC000_0003);
        acc(0, 8'hFC, 0, rd, er, cyc);
        chk(rd == 32'h122B_0007, "R10 ident", rd, 32'h122B_0007);
        acc(0, 8'h08, 0, rd, er, cyc);
        chk(rd == 32'h0, "R1 unmapped", rd, 32'h0);

        // Sweep wait states and every increment-field encoding.
        for (int w = 0; w < 3; w++) begin
            for (int ic = 0; ic < 4; ic++) begin
                wait_cfg = w;
                acc(1, 8'h00, 32'h8000_0000 | (ic << 4), rd, er, cyc);
                acc(0, 8'h00, 0, rd, er, cyc);
                chk(rd == (32'h8000_0042 | (ic << 4)), "R1 inc field", rd, 32'h8000_0042 | (ic << 4));
                acc(1, 8'h04, 32'h20, rd, er, cyc);
                for (int k = 0; k < 2; k++) begin
                    d = 32'hC0DE_0000 + w * 256 + ic * 16 + k;
                    exp_a = 32'h20 + ((ic == 1) ? 4 * k : 0);
                    acc(1, 8'h0C, d, rd, er, cyc);
                    exp_mem[exp_a[5:2]] = d;
                    chk(last_addr == exp_a, "R4 drw write address", last_addr, exp_a);
                    chk(cyc == 3 + w, "R9 data latency", cyc, 3 + w);
                    chk(er == 1'b0, "R7 no error", {31'd0, er}, 32'd0);
                    chk(mem[exp_a[5:2]] == d, "R9 pwdata", mem[exp_a[5:2]], d);
                end
                acc(0, 8'h04, 0, rd, er, cyc);
                exp_a = 32'h20 + ((ic == 1) ? 8 : 0);
                chk(rd == exp_a, "R6 tar after writes", rd, exp_a);
                acc(1, 8'h04, 32'h20, rd, er, cyc);
                for (int k = 0; k < 2; k++) begin
                    exp_a = 32'h20 + ((ic == 1) ? 4 * k : 0);
                    acc(0, 8'h0C, 0, rd, er, cyc);
                    chk(rd == exp_mem[exp_a[5:2]], "R9 drw read data", rd, exp_mem[exp_a[5:2]]);
                    chk(last_addr == exp_a, "R4 drw read address", last_addr, exp_a);
                end
            end
        end

        // Banked windows with increment on.
        wait_cfg = 1;
        acc(1, 8'h00, 32'h8000_0010, rd, er, cyc);
        acc(1, 8'h04, 32'h0000_0037, rd, er, cyc);
        for (int b = 0; b < 4; b++) begin
            d = 32'hBA00_0000 + b;
            acc(1, 8'h10 + 8'(4 * b), d, rd, er, cyc);
            exp_mem[(32'h30 + 4 * b) >> 2 & 15] = d;
            chk(last_addr == 32'h30 + 4 * b, "R5 bank write address", last_addr, 32'h30 + 4 * b);
        end
        for (int b = 0; b < 4; b++) begin
            acc(0, 8'h10 + 8'(4 * b), 0, rd, er, cyc);
            chk(rd == 32'hBA00_0000 + b, "R5 bank read data", rd, 32'hBA00_0000 + b);
            chk(last_addr == 32'h30 + 4 * b, "R5 bank read address", last_addr, 32'h30 + 4 * b);
        end
        acc(0, 8'h04, 0, rd, er, cyc);
        chk(rd == 32'h34, "R11 bank keeps tar", rd, 32'h34);

        // Error responses.
        err_addr = 32'h48;
        acc(1, 8'h04, 32'h48, rd, er, cyc);
        acc(1, 8'h0C, 32'hDEAD_BEEF, rd, er, cyc);
        chk(er == 1'b1, "R7 write error flag", {31'd0, er}, 32'd1);
        chk(mem[2] == exp_mem[2], "R7 errored write dropped", mem[2], exp_mem[2]);
        acc(0, 8'h04, 0, rd, er, cyc);
        chk(rd == 32'h48, "R7 tar held on error", rd, 32'h48);
        acc(0, 8'h0C, 0, rd, er, cyc);
        chk(er == 1'b1, "R7 read error flag", {31'd0, er}, 32'd1);
        acc(1, 8'h04, 32'h44, rd, er, cyc);
        acc(0, 8'h0C, 0, rd, er, cyc);
        chk(er == 1'b0 && rd == exp_mem[1], "R6 read before error address", rd, exp_mem[1]);
        acc(0, 8'h04, 0, rd, er, cyc);
        chk(rd == 32'h48, "R6 tar step", rd, 32'h48);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule